// File: doc/BRIEF.md
# Bank Access Queue with Work-Bound Admission

This block is the per-bank scheduler that sits between a latency-normalizing request front end and one DRAM bank. Each accepted access carries a read/write flag, a row id, an address and a tag that names the delay-storage slot waiting for the result. Write payloads go into their own FIFO and stay there until the matching write reaches the bank. Accesses go to the bank one at a time and in the order they arrived. Each one keeps the bank busy for a fixed number of cycles.

Admission does not depend on how many entries are queued. The block keeps a running total of the bank cycles still owed to admitted work. It refuses a new access whenever adding one more access time would push that total past the normalized delay. Because of this, every admitted access finishes inside the normalized window. Reads complete with a one-cycle response that carries the stored tag and the data the bank returned. Merging of repeated requests is done upstream, so only distinct accesses ever arrive here.

Top module: `bank_access_queue`

## Requirements
- R1: After reset, `stall`, `bankCmdValid` and `rspValid` are all low, and the owed-work total is zero.
- R2: `stall` is high exactly when the owed-work total plus `LAT` exceeds `DNORM` (defaults 15 and 30).
- R3: An accepted enqueue adds `LAT` to the owed-work total. The total then drops by one in every cycle the bank is busy.
- R4: Accesses reach the bank strictly in arrival order. `bankCmdWrite` (1 = write), `bankCmdRow` and `bankCmdAddr` repeat the values given at enqueue.
- R5: Only one access is in the bank at a time. An access issued in cycle t keeps the bank busy in cycles t to t+LAT-1, and the next access can issue no earlier than cycle t+LAT.
- R6: When the bank is idle and nothing is queued, an access accepted in cycle e issues in cycle e+1.
- R7: Write data is held apart from the access queue. It is presented on `bankCmdData` in the cycle its own write issues, with writes paired to data in arrival order.
- R8: A read issued in cycle t produces `rspValid` in cycle t+LAT. `rspTag` is its enqueue tag and `rspData` is the `bankRdData` value from cycle t+LAT-1.
- R9: A completed write produces no response.
- R10: An enqueue presented while `stall` is high is dropped. No extra bank command or response comes from it, and the owed-work total does not change because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Enqueue attempt |
| reqWrite | input | 1 | 1 = write access |
| reqRow | input | ROW_W | Row id |
| reqAddr | input | ADDR_W | Scheduled address |
| reqTag | input | TAG_W | Delay-storage tag |
| reqData | input | DATA_W | Write payload (used when reqWrite) |
| stall | output | 1 | Admission refused this cycle |
| bankCmdValid | output | 1 | Access issued to the bank this cycle |
| bankCmdWrite | output | 1 | Issued access is a write |
| bankCmdRow | output | ROW_W | Row id of issued access |
| bankCmdAddr | output | ADDR_W | Address of issued access |
| bankCmdData | output | DATA_W | Write payload of issued access |
| bankRdData | input | DATA_W | Read data from the bank |
| rspValid | output | 1 | Read response valid |
| rspTag | output | TAG_W | Tag of the completed read |
| rspData | output | DATA_W | Read data |

## Verification
Directed sequences cover several situations. A lone read shows the exact issue and response cycles. A back-to-back pair fills the work budget, and its stall window shows whether work is charged per access and drained per busy cycle rather than counted by occupancy. Enqueues held against an asserted stall show whether a rejected request leaks into the queue. A write followed by a read of the same address shows whether write data is paired with its own access. Random traffic at light, medium and saturating offered loads, with mixed reads and writes, compares every cycle against a reference scheduler. This exposes ordering slips, off-by-one issue spacing and tag mix-ups that only appear when queue and bank activity overlap.

// File: rtl/bq_pkg.sv
package bq_pkg;
  typedef struct packed {
    logic push;       // accept request into the queue
    logic pushWrite;  // accepted request is a write: store payload
    logic pop;        // issue head access to the bank
    logic popWrite;   // issued access is a write: release payload
    logic capture;    // last busy cycle of the in-service access
  } bq_strobe_t;
endpackage

// File: rtl/bq_fifo.sv
module bq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= pushData;
        wrPtr        <= bump(wrPtr);
      end
      if (pop) rdPtr <= bump(rdPtr);
      if (push && !pop)      count <= count + CNT_W'(1);
      else if (pop && !push) count <= count - CNT_W'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (push && full) |-> pop) else $error("fifo overflow"); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty) else $error("fifo underflow"); // R4
endmodule

// File: rtl/bq_ctrl.sv
module bq_ctrl
  import bq_pkg::*;
#(
  parameter int LAT   = 15,
  parameter int DNORM = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       qEmpty,
  input  logic       headWrite,
  output logic       stall,
  output bq_strobe_t str
);
  localparam int WORK_W = $clog2(DNORM + LAT + 1);
  localparam int REM_W  = $clog2(LAT + 1);

  logic [WORK_W-1:0] workCnt, workSum;
  logic [REM_W-1:0]  remCnt;
  logic accept, issue, busy, lastCycle;

  assign workSum   = workCnt + WORK_W'(LAT);
  assign stall     = workSum > WORK_W'(DNORM);
  assign accept    = reqValid && !stall;
  assign issue     = !qEmpty && (remCnt == '0);
  assign busy      = issue || (remCnt != '0);
  assign lastCycle = issue ? (LAT == 1) : (remCnt == REM_W'(1));

  always_comb begin
    str           = '0;
    str.push      = accept;
    str.pushWrite = accept && reqWrite;
    str.pop       = issue;
    str.popWrite  = issue && headWrite;
    str.capture   = lastCycle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workCnt <= '0;
      remCnt  <= '0;
    end else begin
      workCnt <= workCnt + (accept ? WORK_W'(LAT) : '0) - (busy ? WORK_W'(1) : '0);
      if (issue)               remCnt <= REM_W'(LAT - 1);
      else if (remCnt != '0)   remCnt <= remCnt - REM_W'(1);
    end
  end

  AST_WORK_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    workCnt <= WORK_W'(DNORM)) else $error("work above bound"); // R2
  AST_QUEUE_IMPLIES_WORK: assert property (@(posedge clk) disable iff (!rstN)
    !qEmpty |-> (workCnt >= WORK_W'(LAT))) else $error("queued work not charged"); // R3

  generate
    if (LAT > 1) begin : g_spacing
      AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rstN)
        str.pop |=> !str.pop) else $error("back-to-back issue"); // R5
    end
  endgenerate
endmodule

// File: rtl/bq_datapath.sv
module bq_datapath
  import bq_pkg::*;
#(
  parameter int DEPTH  = 2,
  parameter int ROW_W  = 8,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bq_strobe_t        str,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [DATA_W-1:0] reqData,
  output logic              qEmpty,
  output logic              headWrite,
  output logic              bankCmdValid,
  output logic              bankCmdWrite,
  output logic [ROW_W-1:0]  bankCmdRow,
  output logic [ADDR_W-1:0] bankCmdAddr,
  output logic [DATA_W-1:0] bankCmdData,
  input  logic [DATA_W-1:0] bankRdData,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag,
  output logic [DATA_W-1:0] rspData
);
  localparam int ENT_W = 1 + ROW_W + ADDR_W + TAG_W;

  logic [ENT_W-1:0]  pushEntry, headEntry;
  logic              accFull, wrEmpty, wrFull;
  logic [DATA_W-1:0] wrHead;
  logic [TAG_W-1:0]  headTag, curTag;
  logic              curWrite;

  assign pushEntry = {reqWrite, reqRow, reqAddr, reqTag};
  assign {headWrite, bankCmdRow, bankCmdAddr, headTag} = headEntry;

  bq_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_accQ (
    .clk(clk), .rstN(rstN),
    .push(str.push), .pushData(pushEntry), .pop(str.pop),
    .headData(headEntry), .empty(qEmpty), .full(accFull)
  );

  bq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_wrQ (
    .clk(clk), .rstN(rstN),
    .push(str.pushWrite), .pushData(reqData), .pop(str.popWrite),
    .headData(wrHead), .empty(wrEmpty), .full(wrFull)
  );

  assign bankCmdValid = str.pop;
  assign bankCmdWrite = headWrite;
  assign bankCmdData  = headWrite ? wrHead : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curTag   <= '0;
      rspValid <= 1'b0;
      rspTag   <= '0;
      rspData  <= '0;
    end else begin
      if (str.pop) begin
        curWrite <= headWrite;
        curTag   <= headTag;
      end
      rspValid <= str.capture && !curWrite;
      if (str.capture && !curWrite) begin
        rspTag  <= curTag;
        rspData <= bankRdData;
      end
    end
  end

  AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (str.pop && headWrite) |-> !wrEmpty) else $error("write without payload"); // R7
  AST_NO_WRITE_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (str.capture && curWrite) |=> !rspValid) else $error("write responded"); // R9
  AST_WRQ_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (str.pushWrite && wrFull) |-> str.popWrite) else $error("payload overflow"); // R7
  AST_ACCQ_FULL_POP: assert property (@(posedge clk) disable iff (!rstN)
    (accFull && str.push) |-> str.pop) else $error("queue overflow"); // R2
endmodule

// File: rtl/bank_access_queue.sv
module bank_access_queue
  import bq_pkg::*;
#(
  parameter int LAT    = 15,
  parameter int DNORM  = 30,
  parameter int ROW_W  = 8,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [DATA_W-1:0] reqData,
  output logic              stall,
  output logic              bankCmdValid,
  output logic              bankCmdWrite,
  output logic [ROW_W-1:0]  bankCmdRow,
  output logic [ADDR_W-1:0] bankCmdAddr,
  output logic [DATA_W-1:0] bankCmdData,
  input  logic [DATA_W-1:0] bankRdData,
  output logic              rspValid,
  output logic [TAG_W-1:0]  rspTag,
  output logic [DATA_W-1:0] rspData
);
  localparam int DEPTH = (DNORM / LAT > 0) ? DNORM / LAT : 1;

  bq_strobe_t str;
  logic qEmpty, headWrite;

  bq_ctrl #(.LAT(LAT), .DNORM(DNORM)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite),
    .qEmpty(qEmpty), .headWrite(headWrite),
    .stall(stall), .str(str)
  );

  bq_datapath #(
    .DEPTH(DEPTH), .ROW_W(ROW_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqAddr(reqAddr),
    .reqTag(reqTag), .reqData(reqData),
    .qEmpty(qEmpty), .headWrite(headWrite),
    .bankCmdValid(bankCmdValid), .bankCmdWrite(bankCmdWrite),
    .bankCmdRow(bankCmdRow), .bankCmdAddr(bankCmdAddr), .bankCmdData(bankCmdData),
    .bankRdData(bankRdData),
    .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData)
  );

  AST_REJECT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && stall) |-> !str.push) else $error("stalled request accepted"); // R10
  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!bankCmdValid && !rspValid)) else $error("activity out of reset"); // R1
endmodule

// File: tb/sim_bank_access_queue.sv
module sim_bank_access_queue;
  localparam int CLK_P = 10;
  localparam int LAT = 15, DN = 30;
  localparam int ROW_W = 8, ADDR_W = 8, TAG_W = 4, DATA_W = 16;

  typedef struct {
    bit w; logic [ROW_W-1:0] row; logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0] tag; logic [DATA_W-1:0] data;
  } acc_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic stall, bankCmdValid, bankCmdWrite, rspValid;
  logic [ROW_W-1:0] bankCmdRow;
  logic [ADDR_W-1:0] bankCmdAddr;
  logic [DATA_W-1:0] bankCmdData, bankRdData, rspData;
  logic [TAG_W-1:0] rspTag;

  always #(CLK_P/2) clk = ~clk;

  bank_access_queue #(.LAT(LAT), .DNORM(DN), .ROW_W(ROW_W), .ADDR_W(ADDR_W),
    .TAG_W(TAG_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqAddr(reqAddr), .reqTag(reqTag), .reqData(reqData),
    .stall(stall), .bankCmdValid(bankCmdValid), .bankCmdWrite(bankCmdWrite),
    .bankCmdRow(bankCmdRow), .bankCmdAddr(bankCmdAddr), .bankCmdData(bankCmdData),
    .bankRdData(bankRdData), .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData));

  // bank model
  logic [DATA_W-1:0] bankMem [256];
  logic [ADDR_W-1:0] latAddr = '0;
  initial for (int i = 0; i < 256; i++) bankMem[i] = DATA_W'(i * 7 + 3);
  always @(posedge clk) if (bankCmdValid) begin
    latAddr <= bankCmdAddr;
    if (bankCmdWrite) bankMem[bankCmdAddr] <= bankCmdData;
  end
  assign bankRdData = bankMem[latAddr];

  // reference model
  int checks = 0, errors = 0;
  int mW = 0, mRem = 0;
  acc_t mq[$];
  logic [DATA_W-1:0] refMem [256];
  bit curW = 0, pV = 0, pWr = 0;
  logic [TAG_W-1:0] curTag = '0, pTag = '0;
  logic [DATA_W-1:0] curExp = '0, pData = '0;
  initial for (int i = 0; i < 256; i++) refMem[i] = DATA_W'(i * 7 + 3);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit w, input int row, input int addr,
                      input int tag, input int data, input string lab);
    bit eStall, eIssue, acc, busy, last;
    acc_t h, n;
    reqValid = v; reqWrite = w; reqRow = ROW_W'(row); reqAddr = ADDR_W'(addr);
    reqTag = TAG_W'(tag); reqData = DATA_W'(data);
    #1;
    eStall = (mW + LAT > DN);
    chk(stall == eStall, {lab, " R2 stall"}, stall, eStall);
    eIssue = (mq.size() > 0) && (mRem == 0);
    chk(bankCmdValid == eIssue, {lab, " R5 issue"}, bankCmdValid, eIssue);
    if (eIssue && bankCmdValid) begin
      h = mq[0];
      chk(bankCmdWrite == h.w, {lab, " R4 kind"}, bankCmdWrite, h.w);
      chk(bankCmdRow == h.row, {lab, " R4 row"}, bankCmdRow, h.row);
      chk(bankCmdAddr == h.addr, {lab, " R4 addr"}, bankCmdAddr, h.addr);
      if (h.w) chk(bankCmdData == h.data, {lab, " R7 wdata"}, bankCmdData, h.data);
    end
    chk(rspValid == pV, pWr ? {lab, " R9 no wr rsp"} : {lab, " R8 rsp"}, rspValid, pV);
    if (pV && rspValid) begin
      chk(rspTag == pTag, {lab, " R8 tag"}, rspTag, pTag);
      chk(rspData == pData, {lab, " R8 data"}, rspData, pData);
    end
    acc  = v && !eStall;
    busy = eIssue || (mRem != 0);
    last = eIssue ? (LAT == 1) : (mRem == 1);
    pV = last && !curW; pWr = last && curW; pTag = curTag; pData = curExp;
    if (eIssue) begin
      h = mq.pop_front();
      curW = h.w; curTag = h.tag;
      if (h.w) refMem[h.addr] = h.data;
      curExp = refMem[h.addr];
      mRem = LAT - 1;
    end else if (mRem > 0) mRem--;
    if (acc) begin
      n.w = w; n.row = ROW_W'(row); n.addr = ADDR_W'(addr);
      n.tag = TAG_W'(tag); n.data = DATA_W'(data);
      mq.push_back(n);
    end
    mW = mW + (acc ? LAT : 0) - (busy ? 1 : 0);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string lab);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, lab);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(stall == 0, "R1 stall", stall, 0);
    chk(bankCmdValid == 0, "R1 cmd", bankCmdValid, 0);
    chk(rspValid == 0, "R1 rsp", rspValid, 0);
    @(negedge clk);
    // lone read: issue next cycle, response LAT later
    step(1, 0, 5, 8'h11, 3, 0, "R6");
    idle(LAT + 3, "R6");
    // back-to-back pair fills budget, stall window
    step(1, 0, 1, 8'h20, 1, 0, "R3");
    step(1, 0, 2, 8'h21, 2, 0, "R3");
    // attempts while stalled are dropped
    for (int i = 0; i < 10; i++) step(1, 1, 9, 8'h30, 9, 16'hDEAD, "R10");
    idle(2 * LAT + 4, "R10");
    // write then read same address
    step(1, 1, 4, 8'h40, 5, 16'hBEEF, "R7");
    step(1, 0, 4, 8'h40, 6, 0, "R7");
    idle(2 * LAT + 4, "R7");
    // random traffic at several loads
    for (int blk = 0; blk < 6; blk++) begin
      int p;
      p = (blk % 3 == 0) ? 5 : ((blk % 3 == 1) ? 20 : 90);
      for (int i = 0; i < 500; i++) begin
        bit v;
        v = ($urandom % 100) < p;
        step(v, $urandom % 2, $urandom % 256, $urandom % 32,
             $urandom % 16, $urandom % 65536, "RND");
      end
    end
    idle(2 * LAT + 4, "R8");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule